// File: doc/BRIEF.md
# Glitch-Free Power-of-Two Clock Prescaler

The block takes a fast reference clock and produces a divided system clock for a CPU and the synchronous logic around it. The division factor is a power of two that software picks through a small write port: a strobe and a select code. The new code is held until the current output period ends. It then takes effect at the rising boundary of the output clock. Every high phase and every low phase therefore runs to its full length under a single setting, and the output never shows a runt pulse or a period faster than the old or the new setting.

The undivided base clock is half the reference rate. With division factor N, the output stays high for N reference cycles and low for N reference cycles. Divide-by-1 therefore gives a square wave at half the reference rate, and every edge comes straight from a flip-flop. The divider is a synchronous counter clocked by the reference, with a compare against the selected half length. The output is a register.

A second output can carry the divided clock to a pin. A static enable controls it, and the block samples that enable only at rising boundaries. While reset is asserted, both outputs are low.

Top module: `clkdiv_prescaler`

## Requirements
- R1: With select code c in force, N = 2^c and every output period is N reference cycles high followed by N reference cycles low.
- R2: Select codes above MAX_LOG2 (codes 9 to 15 with the defaults) give the largest factor, N = 256.
- R3: While rst_n is low, clk_out and clk_pin are low. After reset the factor is 1, so the first periods are 1 cycle high and 1 cycle low.
- R4: A code is captured on the reference edge where sel_wr is high. It takes effect at the first rising edge of clk_out after that capture edge. The setting changes only at a rising edge of clk_out.
- R5: No output period around a change is shorter than 2·min(N_old, N_new) reference cycles.
- R6: Measure from the capture edge to the rising edge that closes the first full period at the new factor. That latency L satisfies T2 < L ≤ T1 + T2, where T1 = 2·N_old and T2 = 2·N_new reference cycles.
- R7: Exactly two rising edges of clk_out occur inside that latency window.
- R8: When several codes are written before the next rising boundary, only the last one takes effect.
- R9: clk_pin copies clk_out for a whole period when pin_en was high at the reference edge where that period rose. Otherwise clk_pin stays low for the whole period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast reference clock; every register runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_wr | input | 1 | Write strobe for the select code, one reference cycle per write |
| sel_code | input | SEL_W | Division select code; N = 2^min(code, MAX_LOG2) |
| pin_en | input | 1 | Static enable for the clock pin output |
| clk_out | output | 1 | Registered divided clock for the system |
| clk_pin | output | 1 | Divided clock gated per period for the output pin, low when disabled |

## Verification
A wrong internal state shows up at clk_out as a half-phase of the wrong length. This appears no later than the end of the output period in which the state goes wrong. A held code that is lost or applied late shows as a rising boundary that comes after more than one old period has elapsed, which breaks the latency bound. A stale or early-latched pin enable shows on clk_pin in the very next period, as a pulse where none should be or a missing one. The bench measures every high and low interval and compares them against a scoreboard of expected settings. It also checks each switch for latency and for the number of rising edges inside the window.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

   // Phase of the divided output clock.
   typedef enum logic {
      PH_LOW  = 1'b0,
      PH_HIGH = 1'b1
   } phase_e;

   // Select code to shift amount, saturating at the largest supported factor.
   function automatic int unsigned sel_to_shift(input int unsigned code,
                                                input int unsigned max_log2);
      return (code > max_log2) ? max_log2 : code;
   endfunction

endpackage

// File: rtl/cdiv_sel_ctrl.sv
module cdiv_sel_ctrl #(
   parameter int unsigned SEL_W    = 4,
   parameter int unsigned MAX_LOG2 = 8,
   parameter int unsigned SHIFT_W  = 4
) (
   input  logic               clk_fast,
   input  logic               rst_n,
   input  logic               sel_wr,
   input  logic [SEL_W-1:0]   sel_code,
   input  logic               apply_stb,
   output logic [SHIFT_W-1:0] cur_shift
);
   import clkdiv_pkg::*;

   logic [SHIFT_W-1:0] dec_shift;
   logic [SHIFT_W-1:0] pend_shift;
   logic               pend_vld;
   logic [SHIFT_W-1:0] cur_q;

   always_comb begin
      dec_shift = SHIFT_W'(sel_to_shift(32'(sel_code), MAX_LOG2));
   end

   // Held code waits for the rising boundary; a later write overwrites it.
   always_ff @(posedge clk_fast or negedge rst_n) begin
      if (!rst_n) begin
         pend_shift <= '0;
         pend_vld   <= 1'b0;
         cur_q      <= '0;
      end else begin
         if (apply_stb && pend_vld) begin
            cur_q <= pend_shift;
         end
         if (sel_wr) begin
            pend_shift <= dec_shift;
            pend_vld   <= 1'b1;
         end else if (apply_stb) begin
            pend_vld   <= 1'b0;
         end
      end
   end

   assign cur_shift = cur_q;

   // R2
   shift_clamp_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
      32'(cur_q) <= MAX_LOG2);

   // R8
   pend_keep_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
      (pend_vld && !apply_stb && !sel_wr) |=> (pend_vld && $stable(pend_shift)));

endmodule

// File: rtl/cdiv_phase_gen.sv
module cdiv_phase_gen #(
   parameter int unsigned MAX_LOG2 = 8,
   parameter int unsigned SHIFT_W  = 4,
   parameter int unsigned CNT_W    = 8
) (
   input  logic               clk_fast,
   input  logic               rst_n,
   input  logic [SHIFT_W-1:0] cur_shift,
   output logic               rise_stb,
   output logic               clk_next,
   output logic               clk_out
);
   import clkdiv_pkg::*;

   localparam int unsigned RUN_W = CNT_W + 1;

   phase_e           ph_q;
   phase_e           ph_d;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] half_m1;
   logic             term;

   always_comb begin
      half_m1  = CNT_W'((33'd1 << cur_shift) - 33'd1);
      term     = (cnt_q == half_m1);
      ph_d     = ph_q;
      if (term) begin
         ph_d = (ph_q == PH_HIGH) ? PH_LOW : PH_HIGH;
      end
      clk_next = (ph_d == PH_HIGH);
      rise_stb = term && (ph_q == PH_LOW);
   end

   always_ff @(posedge clk_fast or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ph_q  <= PH_LOW;
      end else begin
         cnt_q <= term ? '0 : cnt_q + 1'b1;
         ph_q  <= ph_d;
      end
   end

   assign clk_out = (ph_q == PH_HIGH);

   // Independent run-length tracker for the half-phase assertion.
   logic [RUN_W-1:0] run_q;
   logic [RUN_W-1:0] half_len;

   always_comb begin
      half_len = RUN_W'(33'd1 << cur_shift);
   end

   always_ff @(posedge clk_fast or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else begin
         run_q <= (clk_next != clk_out) ? RUN_W'(1) : run_q + 1'b1;
      end
   end

   // R1
   cnt_range_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
      cnt_q <= half_m1);

   // R1
   half_len_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
      ((clk_out != $past(clk_out)) && ($past(run_q) != '0))
      |-> ($past(run_q) == $past(half_len)));

endmodule

// File: rtl/cdiv_pin_drv.sv
module cdiv_pin_drv #(
   parameter bit HAS_PIN = 1'b1
) (
   input  logic clk_fast,
   input  logic rst_n,
   input  logic rise_stb,
   input  logic clk_next,
   input  logic pin_en,
   output logic clk_pin
);

   generate
      if (HAS_PIN) begin : g_pin
         logic en_per_q;
         logic pin_q;

         // Enable is taken only at a rising boundary, so a period is never cut.
         always_ff @(posedge clk_fast or negedge rst_n) begin
            if (!rst_n) begin
               en_per_q <= 1'b0;
               pin_q    <= 1'b0;
            end else begin
               if (rise_stb) begin
                  en_per_q <= pin_en;
               end
               pin_q <= clk_next & (rise_stb ? pin_en : en_per_q);
            end
         end

         assign clk_pin = pin_q;
      end else begin : g_nopin
         logic unused_pin_inputs;
         assign unused_pin_inputs = ^{clk_fast, rst_n, rise_stb, clk_next, pin_en};
         assign clk_pin = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/clkdiv_prescaler.sv
module clkdiv_prescaler #(
   parameter int unsigned SEL_W    = 4,
   parameter int unsigned MAX_LOG2 = 8,
   parameter bit          HAS_PIN  = 1'b1
) (
   input  logic             clk_fast,
   input  logic             rst_n,
   input  logic             sel_wr,
   input  logic [SEL_W-1:0] sel_code,
   input  logic             pin_en,
   output logic             clk_out,
   output logic             clk_pin
);

   localparam int unsigned SHIFT_W = $clog2(MAX_LOG2 + 1);
   localparam int unsigned CNT_W   = MAX_LOG2;

   // Elaboration-time parameter checks.
   generate
      if (MAX_LOG2 < 1 || MAX_LOG2 > 16) begin : g_bad_log2
         $error("clkdiv_prescaler: MAX_LOG2 must lie in 1..16");
      end
      if (SEL_W < 1 || SEL_W > 8) begin : g_bad_selw
         $error("clkdiv_prescaler: SEL_W must lie in 1..8");
      end
      if (((1 << SEL_W) - 1) < MAX_LOG2) begin : g_narrow_sel
         $error("clkdiv_prescaler: SEL_W too narrow to reach MAX_LOG2");
      end
   endgenerate

   logic [SHIFT_W-1:0] cur_shift;
   logic               rise_stb;
   logic               clk_next;

   cdiv_sel_ctrl #(
      .SEL_W    (SEL_W),
      .MAX_LOG2 (MAX_LOG2),
      .SHIFT_W  (SHIFT_W)
   ) sel_i (
      .clk_fast  (clk_fast),
      .rst_n     (rst_n),
      .sel_wr    (sel_wr),
      .sel_code  (sel_code),
      .apply_stb (rise_stb),
      .cur_shift (cur_shift)
   );

   cdiv_phase_gen #(
      .MAX_LOG2 (MAX_LOG2),
      .SHIFT_W  (SHIFT_W),
      .CNT_W    (CNT_W)
   ) phase_i (
      .clk_fast  (clk_fast),
      .rst_n     (rst_n),
      .cur_shift (cur_shift),
      .rise_stb  (rise_stb),
      .clk_next  (clk_next),
      .clk_out   (clk_out)
   );

   cdiv_pin_drv #(
      .HAS_PIN (HAS_PIN)
   ) pin_i (
      .clk_fast (clk_fast),
      .rst_n    (rst_n),
      .rise_stb (rise_stb),
      .clk_next (clk_next),
      .pin_en   (pin_en),
      .clk_pin  (clk_pin)
   );

   // R4
   shift_move_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
      (cur_shift != $past(cur_shift)) |-> $rose(clk_out));

   generate
      if (HAS_PIN) begin : g_pin_chk
         // R9
         pin_gate_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
            clk_pin |-> clk_out);

         // R9
         pin_latch_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
            $rose(clk_out) |-> (clk_pin == $past(pin_en)));
      end
   endgenerate

endmodule

// File: tb/clkdiv_prescaler_tb_top.sv
module clkdiv_prescaler_tb_top;

   localparam int SEL_W    = 4;
   localparam int MAX_LOG2 = 8;

   logic             clk;
   logic             rst_n;
   logic             sel_wr;
   logic [SEL_W-1:0] sel_code;
   logic             pin_en;
   logic             clk_out;
   logic             clk_pin;

   clkdiv_prescaler #(
      .SEL_W    (SEL_W),
      .MAX_LOG2 (MAX_LOG2),
      .HAS_PIN  (1'b1)
   ) dut_i (
      .clk_fast (clk),
      .rst_n    (rst_n),
      .sel_wr   (sel_wr),
      .sel_code (sel_code),
      .pin_en   (pin_en),
      .clk_out  (clk_out),
      .clk_pin  (clk_pin)
   );

   initial clk = 1'b0;
   always #5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   bit summed = 1'b0;
   int cyc    = 0;

   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int    n_new;
      int    wr_edge;
      string tag;
   } exp_t;

   exp_t q[$];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic summary();
      if (!summed) begin
         summed = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   function automatic int factor_of(input int code);
      return 1 << ((code > MAX_LOG2) ? MAX_LOG2 : code);
   endfunction

   // ---------------- monitor / scoreboard ----------------
   bit    prev_out   = 1'b0;
   int    last_rise  = -1;
   int    last_fall  = -1;
   int    exp_n      = 1;
   int    old_n      = 1;
   int    periods    = 0;
   bit    en_per     = 1'b0;
   bit    pin_bad    = 1'b0;
   bit    win_active = 1'b0;
   int    win_end    = 0;
   int    win_cnt    = 0;
   string post_tag   = "";
   int    post_n     = 0;

   always @(posedge clk) begin
      #2;
      if (rst_n && !done) begin
         bit rise;
         bit fall;
         rise = clk_out && !prev_out;
         fall = !clk_out && prev_out;
         if (rise) en_per = pin_en;
         if (clk_pin !== (clk_out & en_per)) pin_bad = 1'b1;
         if (fall) last_fall = cyc;
         if (rise) begin
            if (last_rise >= 0) begin
               int hi;
               int lo;
               int mn;
               hi = last_fall - last_rise;
               lo = cyc - last_fall;
               mn = (old_n < exp_n) ? old_n : exp_n;
               if (periods == 0)
                  chk(hi == 1 && lo == 1, "R3", hi * 1000 + lo, 1001);
               chk(hi == exp_n, "R1 high", hi, exp_n);
               chk(lo == exp_n, "R1 low", lo, exp_n);
               chk(hi + lo >= 2 * mn, "R5", hi + lo, 2 * mn);
               chk(!pin_bad, "R9", pin_bad, 0);
               if (post_tag != "") begin
                  chk(hi == post_n && lo == post_n, post_tag, hi, post_n);
                  post_tag = "";
               end
               pin_bad = 1'b0;
               periods++;
            end
            if (win_active) begin
               win_cnt++;
               if (cyc >= win_end) begin
                  chk(win_cnt == 2 && cyc == win_end, "R7", win_cnt, 2);
                  win_active = 1'b0;
               end
            end
            if (q.size() > 0 && q[0].wr_edge < cyc) begin
               exp_t it;
               int   lat;
               it  = q.pop_front();
               lat = cyc + 2 * it.n_new - it.wr_edge;
               chk(lat > 2 * it.n_new, "R6 lower", lat, 2 * it.n_new + 1);
               chk(lat <= 2 * exp_n + 2 * it.n_new, "R6 upper", lat, 2 * exp_n + 2 * it.n_new);
               // R4: first rising edge after capture is where the new factor starts
               chk(cyc - it.wr_edge <= 2 * exp_n, "R4", cyc - it.wr_edge, 2 * exp_n);
               old_n      = exp_n;
               exp_n      = it.n_new;
               win_active = 1'b1;
               win_end    = cyc + 2 * it.n_new;
               win_cnt    = 1;
               if (it.tag != "") begin
                  post_tag = it.tag;
                  post_n   = it.n_new;
               end
            end else if (!win_active) begin
               old_n = exp_n;
            end
            last_rise = cyc;
         end
         prev_out = clk_out;
      end
   end

   // ---------------- driver ----------------
   task automatic settle();
      wait (q.size() == 0 && !win_active);
      repeat ($urandom_range(0, 40)) @(negedge clk);
   endtask

   task automatic write_code(input int code, input string tag);
      exp_t it;
      @(negedge clk);
      it.n_new   = factor_of(code);
      it.wr_edge = cyc + 1;
      it.tag     = tag;
      sel_code   = SEL_W'(code);
      sel_wr     = 1'b1;
      q.push_back(it);
      @(negedge clk);
      sel_wr = 1'b0;
      settle();
   endtask

   // Two writes inside one period; only the second may take effect.
   task automatic double_write(input int first, input int second);
      exp_t it;
      @(posedge clk_out);
      @(negedge clk);
      sel_code = SEL_W'(first);
      sel_wr   = 1'b1;
      @(negedge clk);
      it.n_new   = factor_of(second);
      it.wr_edge = cyc + 1;
      it.tag     = "R8";
      sel_code   = SEL_W'(second);
      q.push_back(it);
      @(negedge clk);
      sel_wr = 1'b0;
      settle();
   endtask

   initial begin
      rst_n    = 1'b0;
      sel_wr   = 1'b0;
      sel_code = '0;
      pin_en   = 1'b1;
      repeat (4) @(negedge clk);
      chk(clk_out == 1'b0, "R3 clk_out in reset", clk_out, 0);
      chk(clk_pin == 1'b0, "R3 clk_pin in reset", clk_pin, 0);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      write_code(1, "");
      write_code(0, "");
      write_code(3, "");
      write_code(2, "");
      write_code(9, "R2");
      write_code(0, "");
      write_code(15, "R2");
      write_code(5, "");
      double_write(1, 4);
      double_write(6, 2);
      for (int i = 0; i < 14; i++) begin
         write_code($urandom_range(0, 6), "");
      end
      write_code(8, "");
      write_code(8, "");
      write_code(0, "");
      repeat (60) @(negedge clk);
      done = 1'b1;
      summary();
   end

   // Pin enable flips at random points, independent of the output phase.
   initial begin
      while (!done) begin
         repeat ($urandom_range(5, 60)) @(negedge clk);
         pin_en = ~pin_en;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         summary();
      end
   end

endmodule